// File: doc/BRIEF.md
# Grouped Condition-Code Branch Evaluator

This block resolves a conditional coprocessor branch that looks at several floating-point condition-code bits at once. The branch does not test a single code. It tests an aligned group of two or four codes and is taken when any code in the group equals a true/false sense bit carried in the instruction. In the same cycle the block works out the branch target from the delay-slot address and a signed word offset. A base index that does not line up with the group size is reported as unpredictable.

The fetch stage presents the instruction word, the current eight condition codes and the address of the delay-slot instruction, and raises a valid strobe. One clock later the registered result is on the outputs: taken, target, which group form was decoded, and the unpredictable flag. The redirect takes effect after the delay-slot instruction, and that sequencing belongs to the surrounding pipeline.

Top module: `grouped_cc_branch`

## Requirements
- R1: While the active-low synchronous reset is asserted, every output is zero at each clock edge.
- R2: Outputs are registered. Each output reflects the inputs sampled at the previous rising edge when `valid_i` was high. A cycle sampled with `valid_i` low gives zero on every output.
- R3: An instruction is recognised only when bits 31:26 are 010001 and bits 25:21 are 01001 (two-code form, `group_o` = 2'b01) or 01010 (four-code form, `group_o` = 2'b10). Any other word gives `group_o` = 2'b00, `taken_o` = 0, `unpred_o` = 0 and `target_o` = 0.
- R4: A word whose bit 17 is 1 is not recognised, even when its opcode fields match. It gives the same all-zero result as in R3.
- R5: In the two-code form, with base index b = bits 20:18 and sense s = bit 16, the branch is taken when `cc_i[b]` or `cc_i[b+1]` equals s.
- R6: In the four-code form, the branch is taken when any of `cc_i[b]` through `cc_i[b+3]` equals s.
- R7: An odd base in the two-code form, or a base that is not a multiple of four in the four-code form, sets `unpred_o` to 1 and forces `taken_o` to 0 whatever the codes are.
- R8: For a recognised word, misaligned ones included, `target_o` = `slot_pc_i` + (bits 15:0 sign-extended and shifted left by two), modulo 2^ADDR_W.
- R9: `unpred_o` is 0 whenever no form is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Inputs hold a branch candidate this cycle |
| insn_i | input | 32 | Instruction word |
| cc_i | input | 8 | Floating-point condition codes, bit i is code i |
| slot_pc_i | input | ADDR_W (64) | Address of the delay-slot instruction |
| taken_o | output | 1 | Branch taken |
| target_o | output | ADDR_W (64) | Branch target address |
| group_o | output | 2 | Decoded form: 01 two-code, 10 four-code, 00 none |
| unpred_o | output | 1 | Misaligned group base |

## Verification
The condition test and the alignment check act on the same word in the same cycle. A misaligned base paired with codes that would satisfy the sense shows whether the unpredictable path overrides a real hit. The bench drives two-code words with odd bases and four-code words with bases 2 and 6, each with codes chosen so the group matches. The scoreboard then expects `unpred_o` high, `taken_o` low, and a target that is still computed.

// File: rtl/grouped_cc_branch.sv
module grouped_cc_branch #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [7:0]        cc_i,
  input  logic [ADDR_W-1:0] slot_pc_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [1:0]        group_o,
  output logic              unpred_o
);

  localparam int          CC_W     = 8;
  localparam int          OFF_W    = 16;
  localparam int          EXT_W    = ADDR_W - OFF_W - 2;
  localparam logic [5:0]  OP_COP   = 6'b010001;
  localparam logic [4:0]  FMT_PAIR = 5'b01001;
  localparam logic [4:0]  FMT_QUAD = 5'b01010;

  logic [2:0]        base;
  logic              sense;
  logic [OFF_W-1:0]  off;
  logic              fields_ok, is_pair, is_quad;
  logic [CC_W-1:0]   eq;
  logic [2*CC_W-1:0] rot;
  logic              pair_hit, quad_hit, pair_mis, quad_mis;
  logic              d_taken, d_unpred;
  logic [1:0]        d_group;
  logic [ADDR_W-1:0] d_target;

  assign base      = insn_i[20:18];
  assign sense     = insn_i[16];
  assign off       = insn_i[OFF_W-1:0];
  assign fields_ok = (insn_i[31:26] == OP_COP) && !insn_i[17];
  assign is_pair   = fields_ok && (insn_i[25:21] == FMT_PAIR);
  assign is_quad   = fields_ok && (insn_i[25:21] == FMT_QUAD);

  assign eq       = ~(cc_i ^ {CC_W{sense}});
  assign rot      = {eq, eq} >> base;
  assign pair_hit = |rot[1:0];
  assign quad_hit = |rot[3:0];
  assign pair_mis = base[0];
  assign quad_mis = |base[1:0];

  assign d_group  = valid_i ? {is_quad, is_pair} : 2'b00;
  assign d_taken  = valid_i && ((is_pair && pair_hit && !pair_mis) ||
                                (is_quad && quad_hit && !quad_mis));
  assign d_unpred = valid_i && ((is_pair && pair_mis) || (is_quad && quad_mis));
  assign d_target = (valid_i && (is_pair || is_quad))
                  ? slot_pc_i + {{EXT_W{off[OFF_W-1]}}, off, 2'b00}
                  : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o  <= 1'b0;
      target_o <= '0;
      group_o  <= 2'b00;
      unpred_o <= 1'b0;
    end else begin
      taken_o  <= d_taken;
      target_o <= d_target;
      group_o  <= d_group;
      unpred_o <= d_unpred;
    end
  end

  a_r7_unpred_blocks_taken: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> !taken_o);
  a_r3_taken_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (group_o != 2'b00));
  a_r3_one_form: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(group_o));
  a_r9_unpred_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> (group_o != 2'b00));
  a_r8_no_target_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    (group_o == 2'b00) |-> (target_o == '0));
  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (group_o == 2'b00 && !taken_o && !unpred_o));
  a_r4_bit17_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[17]) |=> (group_o == 2'b00));

endmodule

// File: tb/test_grouped_cc_branch.sv
module test_grouped_cc_branch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [7:0]  cc_i = '0;
  logic [63:0] slot_pc_i = '0;
  logic        taken_o, unpred_o;
  logic [63:0] target_o;
  logic [1:0]  group_o;

  always #4 clk = ~clk;

  grouped_cc_branch i_grouped_cc_branch (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .cc_i(cc_i), .slot_pc_i(slot_pc_i), .taken_o(taken_o),
    .target_o(target_o), .group_o(group_o), .unpred_o(unpred_o));

  typedef struct {
    logic        taken;
    logic [63:0] target;
    logic [1:0]  group;
    logic        unpred;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  function automatic logic [31:0] mk(input logic [4:0] fmt, input logic [2:0] base,
                                     input logic b17, input logic s, input logic [15:0] off);
    return {6'b010001, fmt, base, b17, s, off};
  endfunction

  function automatic exp_t model(input logic v, input logic [31:0] w, input logic [7:0] cc,
                                 input logic [63:0] pc, input string req);
    exp_t e;
    int   width;
    bit   hit;
    e.taken = 0; e.target = 0; e.group = 0; e.unpred = 0; e.req = req;
    if (v && w[31:26] == 6'b010001 && !w[17] && (w[25:21] == 5'd9 || w[25:21] == 5'd10)) begin
      width = (w[25:21] == 5'd9) ? 2 : 4;
      e.group = (width == 2) ? 2'b01 : 2'b10;
      hit = 0;
      for (int i = 0; i < width; i++)
        if (cc[(int'(w[20:18]) + i) % 8] == w[16]) hit = 1;
      e.unpred = (int'(w[20:18]) % width) != 0;
      e.taken = hit && !e.unpred;
      e.target = pc + (64'(signed'(w[15:0])) <<< 2);
    end
    return e;
  endfunction

  task automatic drive(input logic v, input logic [31:0] w, input logic [7:0] cc,
                       input logic [63:0] pc, input string req);
    @(negedge clk);
    valid_i = v; insn_i = w; cc_i = cc; slot_pc_i = pc;
    q.push_back(model(v, w, cc, pc, req));
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (taken_o !== e.taken || target_o !== e.target || group_o !== e.group ||
          unpred_o !== e.unpred) begin
        fails++;
        $display("FAIL %s: got taken=%0b tgt=%h grp=%b unp=%0b, exp taken=%0b tgt=%h grp=%b unp=%0b",
                 e.req, taken_o, target_o, group_o, unpred_o,
                 e.taken, e.target, e.group, e.unpred);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs at zero despite a takeable branch
    @(negedge clk);
    valid_i = 1; insn_i = mk(5'd9, 3'd0, 0, 1, 16'h0010); cc_i = 8'hFF; slot_pc_i = 64'h100;
    @(posedge clk); #1;
    checks++;
    if (taken_o !== 0 || target_o !== 0 || group_o !== 0 || unpred_o !== 0) begin
      fails++;
      $display("FAIL R1: got taken=%0b tgt=%h grp=%b unp=%0b, exp all zero",
               taken_o, target_o, group_o, unpred_o);
    end
    @(negedge clk);
    rst_n = 1; valid_i = 0;
    mon_on = 1;

    drive(1, mk(5'd9, 3'd0, 0, 1, 16'h0004), 8'h01, 64'h1000, "R5 pair hit low bit");
    drive(1, mk(5'd9, 3'd2, 0, 1, 16'h0004), 8'hF3, 64'h1000, "R5 pair miss");
    drive(1, mk(5'd9, 3'd6, 0, 0, 16'h0008), 8'h7F, 64'h2000, "R5 pair sense false hit");
    drive(1, mk(5'd9, 3'd6, 0, 0, 16'h0008), 8'hFF, 64'h2000, "R5 pair sense false miss");
    drive(1, mk(5'd10, 3'd4, 0, 1, 16'h0001), 8'h80, 64'h3000, "R6 quad hit top");
    drive(1, mk(5'd10, 3'd4, 0, 1, 16'h0001), 8'h0F, 64'h3000, "R6 quad miss");
    drive(1, mk(5'd10, 3'd0, 0, 0, 16'h0001), 8'hF7, 64'h3000, "R6 quad false hit");
    drive(1, mk(5'd9, 3'd3, 0, 1, 16'h0002), 8'hFF, 64'h4000, "R7 pair odd base");
    drive(1, mk(5'd10, 3'd2, 0, 1, 16'h0002), 8'hFF, 64'h4000, "R7 quad base 2");
    drive(1, mk(5'd10, 3'd6, 0, 0, 16'h0002), 8'h00, 64'h4000, "R7 quad base 6");
    drive(1, mk(5'd9, 3'd0, 1, 1, 16'h0002), 8'hFF, 64'h5000, "R4 bit17 set");
    drive(1, {6'b010000, 5'd9, 3'd0, 1'b0, 1'b1, 16'h0002}, 8'hFF, 64'h5000, "R3 bad opcode");
    drive(1, mk(5'd8, 3'd0, 0, 1, 16'h0002), 8'hFF, 64'h5000, "R3 bad form");
    drive(1, mk(5'd9, 3'd1, 1, 1, 16'h0002), 8'hFF, 64'h5000, "R9 unmatched odd base");
    drive(1, mk(5'd9, 3'd0, 0, 1, 16'hFFFF), 8'h01, 64'h0, "R8 negative wrap");
    drive(1, mk(5'd10, 3'd0, 0, 1, 16'h7FFF), 8'h01, 64'h0000_0000_0000_1000, "R8 max positive");
    drive(1, mk(5'd9, 3'd0, 0, 1, 16'h8000), 8'h01, 64'hFFFF_FFFF_FFFF_FFF0, "R8 min negative");
    drive(0, mk(5'd9, 3'd0, 0, 1, 16'h0004), 8'hFF, 64'h1000, "R2 valid low");
    drive(1, mk(5'd10, 3'd4, 0, 1, 16'h0010), 8'h10, 64'h8000, "R2 back to back");
    for (int n = 0; n < 300; n++) begin
      logic [31:0] w;
      w = mk(($urandom % 4 == 0) ? 5'($urandom) : (($urandom % 2) ? 5'd9 : 5'd10),
             3'($urandom), ($urandom % 8 == 0), 1'($urandom), 16'($urandom));
      drive(1'($urandom % 5 != 0), w, 8'($urandom), {32'($urandom), 32'($urandom)},
            "R5 R6 R7 R8 mixed");
    end
    drive(0, '0, '0, '0, "R2 drain");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule